// File: doc/BRIEF.md
# Three-format 16-bit instruction decoder

This block is a purely combinational front-end decoder for a 16-bit instruction word. It looks at the top two bits of the word and places it in one of three encoding formats. Each format has its own opcode width and field layout. The block then extracts the opcode, the register indices and any short immediate or branch displacement.

For the general register format, the block also knows which opcodes carry a trailing 32-bit operand. For those it reports an extension-needed flag and a 6-byte length, and it packs the four trailing bytes, given in address order, into one big-endian word. Encodings with no defined meaning raise an illegal flag. No-operation and breakpoint opcodes each get a flag of their own.

A fetch stage uses the block. It presents the instruction word together with the four bytes that follow it in memory. It reads back the length to advance its fetch pointer and the illegal flag to raise a fault. The block holds no state and has no clock: every output follows its inputs in the same cycle.

Top module: `instr_dec3`

## Requirements
- R1: The format tag is 1 when bit 15 is 0, 2 when bits 15:14 are 10 and 3 when bits 15:14 are 11; the tag is never 0.
- R2: In format 1, the opcode is bits 15:8, the first register index is bits 7:4, the second register index is bits 3:0, and the short immediate and displacement are 0.
- R3: In format 2, the opcode is bits 13:12, zero-extended to 8 bits (0 add immediate, 1 subtract immediate, 2 read special register, 3 write special register). The first register is bits 11:8, the short immediate is bits 7:0 unsigned, and the second register and displacement are 0.
- R4: In format 3, the opcode is the 4-bit condition in bits 13:10, zero-extended. The displacement is bits 9:0 sign-extended to 16 bits and shifted left by one. Both register indices and the short immediate are 0.
- R5: Format 1 opcodes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36 to 0x39 set the extension-needed flag and report a length of 6.
- R6: When the extension-needed flag is set, the extension word is {byte[0], byte[1], byte[2], byte[3]}, where byte[0] is the trailing byte at the lowest address and lands in bits 31:24. When the flag is clear, the extension word is 0.
- R7: The illegal flag is set for format 1 opcodes 0x00, 0x10 to 0x18 and anything above 0x39, and for format 3 conditions above 9. It is never set in format 2.
- R8: An illegal word always reports the extension-needed flag as 0, a length of 2, and both the no-operation and breakpoint flags as 0.
- R9: The no-operation flag is set only for format 1 opcode 0x0F, and the breakpoint flag only for format 1 opcode 0x35.
- R10: Every word without an extension reports a length of 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 16 | Instruction word, most significant byte first in memory |
| trail_bytes | input | 4x8 | Four bytes following the word; index 0 is the lowest address |
| fmt_tag | output | 2 | Encoding format 1, 2 or 3 |
| opcode | output | 8 | Format opcode, zero-extended |
| reg_a | output | 4 | First register index |
| reg_b | output | 4 | Second register index |
| short_imm | output | 8 | Unsigned immediate of format 2 |
| branch_disp | output | 16 | Signed byte displacement of format 3 |
| ext_needed | output | 1 | Word is followed by a 32-bit operand |
| ext_word | output | 32 | Big-endian trailing operand, 0 when unused |
| instr_len | output | 3 | Instruction length in bytes (2 or 6) |
| illegal | output | 1 | Encoding is undefined |
| is_nop | output | 1 | No-operation opcode |
| is_trap | output | 1 | Breakpoint opcode |

## Verification
Two judgements can fall on the same word: the extension table and the illegal check. Both are evaluated on every format 1 opcode. The case where they collide is provoked by sweeping every 7-bit format 1 opcode, including the neighbours 0x18/0x1A and 0x39/0x3A, each time with random non-zero trailing bytes. Each word is judged on its length, its extension flag and a zero extension word, computed by bench functions from a membership mask. Random words of all three formats run alongside, and format 3 sweeps all sixteen conditions with random displacements to cover the sign boundary.

// File: rtl/idec_pkg.sv
package idec_pkg;
    localparam int WORD_W    = 16;
    localparam int REG_W     = 4;
    localparam int OPC_W     = 8;
    localparam int IMM_W     = 8;
    localparam int BYTE_W    = 8;
    localparam int EXT_BYTES = 4;
    localparam int EXT_W     = EXT_BYTES * BYTE_W;
    localparam int DISP_W    = 16;
    localparam int OFS_W     = 10;
    localparam int COND_W    = 4;
    localparam int SUB_W     = 2;
    localparam int LEN_W     = 3;

    typedef enum logic [1:0] {
        FMT_NONE  = 2'd0,
        FMT_ONE   = 2'd1,
        FMT_TWO   = 2'd2,
        FMT_THREE = 2'd3
    } fmt_e;

    localparam logic [OPC_W-1:0]  OPC_NONE     = 8'h00;
    localparam logic [OPC_W-1:0]  OPC_NOP      = 8'h0F;
    localparam logic [OPC_W-1:0]  OPC_HOLE_LO  = 8'h10;
    localparam logic [OPC_W-1:0]  OPC_HOLE_HI  = 8'h18;
    localparam logic [OPC_W-1:0]  OPC_TRAP     = 8'h35;
    localparam logic [OPC_W-1:0]  OPC_LAST     = 8'h39;
    localparam logic [COND_W-1:0] COND_LAST    = 4'd9;
    localparam logic [LEN_W-1:0]  LEN_SHORT    = 3'd2;
    localparam logic [LEN_W-1:0]  LEN_LONG     = 3'd6;
endpackage

// File: rtl/idec_fmt1.sv
module idec_fmt1
    import idec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [OPC_W-1:0]  opc,
    output logic [REG_W-1:0]  ra,
    output logic [REG_W-1:0]  rb,
    output logic              bad,
    output logic              ext,
    output logic              nop,
    output logic              trap,
    output logic [LEN_W-1:0]  len
);
    logic ext_raw;

    always_comb begin
        opc = word[WORD_W-1 -: OPC_W];
        ra  = word[2*REG_W-1 -: REG_W];
        rb  = word[REG_W-1:0];
    end

    always_comb begin
        bad = (opc == OPC_NONE) ||
              ((opc >= OPC_HOLE_LO) && (opc <= OPC_HOLE_HI)) ||
              (opc > OPC_LAST);
    end

    always_comb begin
        unique case (opc)
            8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D,
            8'h1A, 8'h1B, 8'h1D, 8'h1F,
            8'h20, 8'h22, 8'h24,
            8'h30, 8'h36, 8'h37, 8'h38, 8'h39: ext_raw = 1'b1;
            default:                           ext_raw = 1'b0;
        endcase
    end

    always_comb begin
        ext  = ext_raw && !bad;
        len  = ext ? LEN_LONG : LEN_SHORT;
        nop  = (opc == OPC_NOP);
        trap = (opc == OPC_TRAP);
    end
endmodule

// File: rtl/idec_fmt2.sv
module idec_fmt2
    import idec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [OPC_W-1:0]  opc,
    output logic [REG_W-1:0]  ra,
    output logic [IMM_W-1:0]  imm
);
    always_comb begin
        opc = {{(OPC_W-SUB_W){1'b0}}, word[WORD_W-3 -: SUB_W]};
        ra  = word[WORD_W-3-SUB_W -: REG_W];
        imm = word[IMM_W-1:0];
    end
endmodule

// File: rtl/idec_fmt3.sv
module idec_fmt3
    import idec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [OPC_W-1:0]  opc,
    output logic [DISP_W-1:0] disp,
    output logic              bad
);
    logic [COND_W-1:0] cond;

    always_comb begin
        cond = word[WORD_W-3 -: COND_W];
        opc  = {{(OPC_W-COND_W){1'b0}}, cond};
        bad  = (cond > COND_LAST);
        disp = {{(DISP_W-OFS_W-1){word[OFS_W-1]}}, word[OFS_W-1:0], 1'b0};
    end
endmodule

// File: rtl/idec_trail.sv
module idec_trail
    import idec_pkg::*;
(
    input  logic [EXT_BYTES-1:0][BYTE_W-1:0] bytes_in,
    input  logic                              en,
    output logic [EXT_W-1:0]                  word_out
);
    logic [EXT_W-1:0] packed_w;

    for (genvar i = 0; i < EXT_BYTES; i++) begin : g_lane
        assign packed_w[EXT_W-1-BYTE_W*i -: BYTE_W] = bytes_in[i];
    end

    assign word_out = en ? packed_w : '0;
endmodule

// File: rtl/instr_dec3.sv
module instr_dec3
    import idec_pkg::*;
(
    input  logic [15:0]      instr_word,
    input  logic [3:0][7:0]  trail_bytes,
    output logic [1:0]       fmt_tag,
    output logic [7:0]       opcode,
    output logic [3:0]       reg_a,
    output logic [3:0]       reg_b,
    output logic [7:0]       short_imm,
    output logic [15:0]      branch_disp,
    output logic             ext_needed,
    output logic [31:0]      ext_word,
    output logic [2:0]       instr_len,
    output logic             illegal,
    output logic             is_nop,
    output logic             is_trap
);
    fmt_e              fmt;
    logic [OPC_W-1:0]  f1_opc, f2_opc, f3_opc;
    logic [REG_W-1:0]  f1_ra, f1_rb, f2_ra;
    logic [IMM_W-1:0]  f2_imm;
    logic [DISP_W-1:0] f3_disp;
    logic              f1_bad, f1_ext, f1_nop, f1_trap, f3_bad;
    logic [LEN_W-1:0]  f1_len;
    logic              take_ext;

    idec_fmt1 u_f1 (
        .word (instr_word), .opc (f1_opc), .ra (f1_ra), .rb (f1_rb),
        .bad (f1_bad), .ext (f1_ext), .nop (f1_nop), .trap (f1_trap),
        .len (f1_len)
    );

    idec_fmt2 u_f2 (
        .word (instr_word), .opc (f2_opc), .ra (f2_ra), .imm (f2_imm)
    );

    idec_fmt3 u_f3 (
        .word (instr_word), .opc (f3_opc), .disp (f3_disp), .bad (f3_bad)
    );

    always_comb begin
        if (!instr_word[WORD_W-1])     fmt = FMT_ONE;
        else if (instr_word[WORD_W-2]) fmt = FMT_THREE;
        else                           fmt = FMT_TWO;
    end

    assign take_ext = (fmt == FMT_ONE) && f1_ext;

    idec_trail u_trail (
        .bytes_in (trail_bytes), .en (take_ext), .word_out (ext_word)
    );

    always_comb begin
        fmt_tag     = fmt;
        opcode      = '0;
        reg_a       = '0;
        reg_b       = '0;
        short_imm   = '0;
        branch_disp = '0;
        ext_needed  = 1'b0;
        instr_len   = LEN_SHORT;
        illegal     = 1'b0;
        is_nop      = 1'b0;
        is_trap     = 1'b0;
        unique case (fmt)
            FMT_ONE: begin
                opcode     = f1_opc;
                reg_a      = f1_ra;
                reg_b      = f1_rb;
                ext_needed = f1_ext;
                instr_len  = f1_len;
                illegal    = f1_bad;
                is_nop     = f1_nop;
                is_trap    = f1_trap;
            end
            FMT_TWO: begin
                opcode    = f2_opc;
                reg_a     = f2_ra;
                short_imm = f2_imm;
            end
            FMT_THREE: begin
                opcode      = f3_opc;
                branch_disp = f3_disp;
                illegal     = f3_bad;
            end
            default: begin
                opcode = '0;
            end
        endcase
    end

    always_comb begin
        if (!$isunknown(instr_word) && !$isunknown(trail_bytes)) begin
            // R8
            illegal_no_ext_chk: assert (!illegal || (!ext_needed && instr_len == LEN_SHORT
                                                     && !is_nop && !is_trap));
            // R5
            len_matches_ext_chk: assert (instr_len == (ext_needed ? LEN_LONG : LEN_SHORT));
            // R6
            ext_word_idle_chk: assert (ext_needed || ext_word == '0);
            // R1
            fmt_defined_chk: assert (fmt_tag != FMT_NONE);
            // R9
            nop_trap_excl_chk: assert (!(is_nop && is_trap) &&
                                       (!(is_nop || is_trap) || fmt_tag == FMT_ONE));
            // R7
            fmt2_legal_chk: assert (fmt_tag != FMT_TWO || !illegal);
        end
    end
endmodule

// File: tb/tb_instr_dec3.sv
module tb_instr_dec3;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [15:0]     instr_word;
    logic [3:0][7:0] trail_bytes;
    logic [1:0]      fmt_tag;
    logic [7:0]      opcode;
    logic [3:0]      reg_a, reg_b;
    logic [7:0]      short_imm;
    logic [15:0]     branch_disp;
    logic            ext_needed;
    logic [31:0]     ext_word;
    logic [2:0]      instr_len;
    logic            illegal, is_nop, is_trap;

    instr_dec3 dut (
        .instr_word (instr_word), .trail_bytes (trail_bytes),
        .fmt_tag (fmt_tag), .opcode (opcode), .reg_a (reg_a), .reg_b (reg_b),
        .short_imm (short_imm), .branch_disp (branch_disp),
        .ext_needed (ext_needed), .ext_word (ext_word), .instr_len (instr_len),
        .illegal (illegal), .is_nop (is_nop), .is_trap (is_trap)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] long_mask;
    logic finished = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic bad_f1(input int op);
        return (op == 0) || (op >= 16 && op <= 24) || (op > 57);
    endfunction

    task automatic apply(input logic [15:0] w, input logic [3:0][7:0] tb);
        int          f;
        logic [31:0] e_opc, e_ra, e_rb, e_imm, e_disp, e_word;
        logic        e_ext, e_ill, e_nop, e_trp;
        int          op;
        @(negedge clk);
        instr_word  = w;
        trail_bytes = tb;
        #1;
        e_opc = 0; e_ra = 0; e_rb = 0; e_imm = 0; e_disp = 0;
        e_ext = 0; e_ill = 0; e_nop = 0; e_trp = 0;
        if (w[15] == 1'b0) begin
            f = 1; op = int'(w >> 8);
            e_opc = op; e_ra = (w >> 4) & 16'hF; e_rb = w & 16'hF;
            e_ill = bad_f1(op);
            e_ext = !e_ill && long_mask[op];
            e_nop = (op == 15) && !e_ill;
            e_trp = (op == 53) && !e_ill;
        end else if (w[14] == 1'b0) begin
            f = 2;
            e_opc = (w >> 12) & 3; e_ra = (w >> 8) & 15; e_imm = w & 255;
        end else begin
            f = 3;
            e_opc = (w >> 10) & 15;
            e_ill = e_opc > 9;
            e_disp = ((w & 10'h3FF) >= 512) ? (32'h0000_FC00 | ((w & 10'h3FF) << 1)) & 32'hFFFF
                                            : (w & 10'h3FF) << 1;
        end
        e_word = e_ext ? (tb[0] * 32'h0100_0000 + tb[1] * 32'h0001_0000
                          + tb[2] * 32'h0000_0100 + tb[3]) : 32'h0;
        chk("R1", "fmt", fmt_tag, f);
        chk(f == 1 ? "R2" : (f == 2 ? "R3" : "R4"), "opcode", opcode, e_opc);
        chk(f == 1 ? "R2" : "R3", "reg_a", reg_a, e_ra);
        chk(f == 1 ? "R2" : "R4", "reg_b", reg_b, e_rb);
        chk(f == 2 ? "R3" : "R2", "short_imm", short_imm, e_imm);
        chk("R4", "disp", branch_disp, e_disp);
        chk(e_ill ? "R8" : "R5", "ext_needed", ext_needed, e_ext);
        chk(e_ext ? "R5" : "R10", "len", instr_len, e_ext ? 6 : 2);
        chk("R6", "ext_word", ext_word, e_word);
        chk("R7", "illegal", illegal, e_ill);
        chk("R9", "nop", is_nop, e_nop);
        chk("R9", "trap", is_trap, e_trp);
    endtask

    function automatic logic [3:0][7:0] rnd_bytes();
        logic [3:0][7:0] b;
        for (int i = 0; i < 4; i++) b[i] = 8'($urandom_range(1, 255));
        return b;
    endfunction

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int longs[18] = '{1, 3, 8, 9, 12, 13, 26, 27, 29, 31, 32, 34, 36, 48, 54, 55, 56, 57};
        void'($urandom(32'd4242));
        long_mask = '0;
        foreach (longs[k]) long_mask[longs[k]] = 1'b1;
        instr_word  = 16'h0F00;
        trail_bytes = '0;

        // Directed: byte order with a known operand (R6)
        apply(16'h0120, '{8'h78, 8'h56, 8'h34, 8'h12});
        // Illegal neighbours of extended opcodes (R7, R8)
        apply(16'h1800, rnd_bytes());
        apply(16'h3A00, rnd_bytes());
        apply(16'h0000, rnd_bytes());
        // Breakpoint and no-op (R9)
        apply(16'h3500, rnd_bytes());
        apply(16'h0F00, rnd_bytes());
        // Format 2 sub-opcodes with extreme immediates (R3)
        apply(16'hBFFF, rnd_bytes());
        apply(16'h8000, rnd_bytes());
        // Displacement sign boundary (R4)
        apply(16'hC1FF, rnd_bytes());
        apply(16'hC200, rnd_bytes());
        apply(16'hE7FF, rnd_bytes());

        // Sweep every format 1 opcode (R5, R7, R10)
        for (int op = 0; op < 128; op++)
            apply({op[7:0], 8'($urandom)}, rnd_bytes());
        // Sweep every format 3 condition (R4, R7)
        for (int c = 0; c < 16; c++)
            apply({2'b11, c[3:0], 10'($urandom)}, rnd_bytes());
        // Random words across all formats
        for (int n = 0; n < 1500; n++)
            apply(16'($urandom), rnd_bytes());

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule